// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

An eight-bit general-purpose I/O port. Every bit has a direction flag and a level flag, both held in registers that software reaches through a small register bus. Together the two flags pick one of four pad modes: float, input with pull-up, drive low or drive high. The level flag has a double role. On an output it sets the driven value. On an input it asks for the weak pull-up. A chip-wide pull-up kill input overrides every pull-up request.

The pad level comes back through a latch followed by a flop. The latch passes the pad while the clock is low and holds it while the clock is high. The flop captures the latch at the rising edge. The captured value is readable at any time, whatever the direction, so a driven pin reads back its own level.

The direction and level registers are written separately. A change between two modes that differ in both flags therefore takes two writes, and the pads show the mode in between for at least one cycle. The block exposes that step and never hides it.

Top module: `gpio_port`

## Requirements
- R1: While rst is high at a rising edge, the direction register, level register and sampled-pin register all clear to 0x00. Once reset ends and before any write, pad_oe = 0x00, pad_out = 0x00 and pad_pu = 0x00.
- R2: A rising edge with wr_en high and addr = 1 loads wr_data into the direction register. With addr = 2 it loads the level register. rd_data is combinational: addr 0 gives the sampled pins, 1 the direction register, 2 the level register and 3 gives 0x00. A read has no side effects.
- R3: A write with addr = 0 or addr = 3 changes no register and no pad output.
- R4: A bit with direction 0 and level 0 floats: pad_oe = 0, pad_out = 0 and pad_pu = 0.
- R5: A bit with direction 0 and level 1 is an input with pad_pu = 1 while pu_disable is 0. Its pad_oe and pad_out stay 0.
- R6: While pu_disable is 1, pad_pu is 0x00 on every bit, whatever the two registers hold.
- R7: A bit with direction 1 has pad_oe = 1, pad_out equal to its level bit and pad_pu = 0.
- R8: Each write changes only the register it addresses. A move from float (00) to drive high (11) done as two writes shows the pull-up state (01) on the pads for the cycle between the writes.
- R9: The sampled-pin register follows pad_in on every bit, whatever the direction, so a driven bit reads back the level on its pad.
- R10: A pad_in level that is held through a low clock phase appears in the sampled-pin register at the next rising edge. The register does not change between rising edges.
- R11: A pad_in pulse that starts and ends inside one high clock phase is never captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the input latch passes data while clk is low |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 pins, 1 direction, 2 level |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for addr |
| pu_disable | input | 1 | Chip-wide pull-up kill |
| pad_in | input | 8 | Raw pad levels |
| pad_oe | output | 8 | Per-bit output enable |
| pad_out | output | 8 | Per-bit drive value, 0 when not enabled |
| pad_pu | output | 8 | Per-bit pull-up enable |

## Verification
A register write takes effect at the rising edge that samples it. The pads and rd_data show the new value from that edge onward, so the bench drives the bus just after a falling edge and checks at the following falling edge. For pad input, the bench places edges both in the low phase and in the high phase. It reads the pin register just before and just after each rising edge, to show the one edge at which the new level arrives. A pulse kept inside one high phase is checked two edges later, to show it was never captured. The mode table is applied with pu_disable at both values, and each entry is read back one cycle after its writes.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_PIN   = 2'd0,
        SEL_DIR   = 2'd1,
        SEL_LEVEL = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        MODE_FLOAT   = 2'b00,
        MODE_PULLUP  = 2'b01,
        MODE_DRV_LO  = 2'b10,
        MODE_DRV_HI  = 2'b11
    } pin_mode_e;

    typedef struct packed {
        logic oe;
        logic drv;
        logic pu;
    } pad_ctl_t;

    function automatic pin_mode_e mode_of(input logic dir, input logic lvl);
        return pin_mode_e'({dir, lvl});
    endfunction

    function automatic pad_ctl_t pad_ctl_of(input pin_mode_e m, input logic pu_kill);
        pad_ctl_t c;
        c = '0;
        case (m)
            MODE_FLOAT:  c = '0;
            MODE_PULLUP: c.pu = !pu_kill;
            MODE_DRV_LO: c.oe = 1'b1;
            MODE_DRV_HI: begin
                c.oe  = 1'b1;
                c.drv = 1'b1;
            end
            default:     c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [WIDTH-1:0]  pin_q,
    output logic [WIDTH-1:0]  rd_data,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  lvl_q
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            lvl_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_DIR:   dir_q <= wr_data;
                SEL_LEVEL: lvl_q <= wr_data;
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            SEL_PIN:   rd_data = pin_q;
            SEL_DIR:   rd_data = dir_q;
            SEL_LEVEL: rd_data = lvl_q;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/gpio_pad_decode.sv
`timescale 1ns/1ps
module gpio_pad_decode
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] lvl_q,
    input  logic             pu_disable,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pu
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        pad_ctl_t ctl;
        assign ctl        = pad_ctl_of(mode_of(dir_q[i], lvl_q[i]), pu_disable);
        assign pad_oe[i]  = ctl.oe;
        assign pad_out[i] = ctl.drv;
        assign pad_pu[i]  = ctl.pu;
    end

endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] pin_q
);

    // Stage one: transparent during the low phase, holds during the high phase.
    always_latch begin
        if (!clk) latch_q = pad_in;
    end

    // Stage two: captures the held latch value at the rising edge.
    always_ff @(posedge clk) begin
        if (rst) pin_q <= '0;
        else     pin_q <= latch_q;
    end

endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wr_data,
    output logic [WIDTH-1:0]  rd_data,
    input  logic              pu_disable,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_pu
);

    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] lvl_q;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] pin_q;

    gpio_in_sync #(.WIDTH(WIDTH)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pad_in  (pad_in),
        .latch_q (latch_q),
        .pin_q   (pin_q)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .pin_q   (pin_q),
        .rd_data (rd_data),
        .dir_q   (dir_q),
        .lvl_q   (lvl_q)
    );

    gpio_pad_decode #(.WIDTH(WIDTH)) u_decode (
        .dir_q      (dir_q),
        .lvl_q      (lvl_q),
        .pu_disable (pu_disable),
        .pad_oe     (pad_oe),
        .pad_out    (pad_out),
        .pad_pu     (pad_pu)
    );

endmodule

// File: rtl/gpio_port_chk.sv
`timescale 1ns/1ps
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [WIDTH-1:0]  wr_data,
    input logic              pu_disable,
    input logic [WIDTH-1:0]  pad_oe,
    input logic [WIDTH-1:0]  pad_pu,
    input logic [WIDTH-1:0]  dir_q,
    input logic [WIDTH-1:0]  lvl_q,
    input logic [WIDTH-1:0]  latch_q,
    input logic [WIDTH-1:0]  pin_q
);

    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (pad_oe == '0 && pad_pu == '0 && pin_q == '0));

    p_dir_load_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && $past(addr) == SEL_DIR) |-> dir_q == $past(wr_data));

    p_lvl_load_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && $past(addr) == SEL_LEVEL) |-> lvl_q == $past(wr_data));

    p_no_stray_write_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !($past(wr_en) && ($past(addr) == SEL_DIR || $past(addr) == SEL_LEVEL)))
        |-> ($stable(dir_q) && $stable(lvl_q)));

    p_float_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe | pad_pu) & ~dir_q & ~lvl_q) == '0);

    p_pu_kill_r6: assert property (@(posedge clk) disable iff (rst)
        pu_disable |-> pad_pu == '0);

    p_no_pu_on_drive_r7: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & pad_pu) == '0);

    p_sync_path_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> pin_q == $past(latch_q));

endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .addr       (addr),
    .wr_data    (wr_data),
    .pu_disable (pu_disable),
    .pad_oe     (pad_oe),
    .pad_pu     (pad_pu),
    .dir_q      (dir_q),
    .lvl_q      (lvl_q),
    .latch_q    (latch_q),
    .pin_q      (pin_q)
);

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [1:0] addr;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       pu_disable;
    logic [7:0] pad_in;
    logic [7:0] pad_oe;
    logic [7:0] pad_out;
    logic [7:0] pad_pu;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    gpio_port u_dut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .addr       (addr),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .pu_disable (pu_disable),
        .pad_in     (pad_in),
        .pad_oe     (pad_oe),
        .pad_out    (pad_out),
        .pad_pu     (pad_pu)
    );

    // {dir, level, pu_disable(0x00/0x01), exp_oe, exp_out, exp_pu}
    localparam logic [47:0] VEC [8] = '{
        {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
        {8'hCC, 8'hAA, 8'h00, 8'hCC, 8'h88, 8'h22},
        {8'hCC, 8'hAA, 8'h01, 8'hCC, 8'h88, 8'h00},
        {8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'hFF},
        {8'h00, 8'hFF, 8'h01, 8'h00, 8'h00, 8'h00},
        {8'hFF, 8'h5A, 8'h00, 8'hFF, 8'h5A, 8'h00},
        {8'h0F, 8'hF0, 8'h00, 8'h0F, 8'h00, 8'hF0},
        {8'hF0, 8'h3C, 8'h01, 8'hF0, 8'h30, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #0.1;
        d = rd_data;
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        rst = 1'b1; wr_en = 1'b0; addr = 2'd0; wr_data = 8'h00;
        pu_disable = 1'b0; pad_in = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_out", pad_out, 8'h00);
        check("R1 pad_pu", pad_pu, 8'h00);
        read_reg(2'd1, rv); check("R1 dir", rv, 8'h00);
        read_reg(2'd2, rv); check("R1 level", rv, 8'h00);
        read_reg(2'd0, rv); check("R1 pins", rv, 8'h00);

        // R4 R5 R6 R7 mode table
        for (int k = 0; k < 8; k++) begin
            pu_disable = VEC[k][24];
            bus_write(2'd1, VEC[k][47:40]);
            bus_write(2'd2, VEC[k][39:32]);
            check("R4/R5/R6/R7 oe", pad_oe, VEC[k][23:16]);
            check("R4/R5/R6/R7 out", pad_out, VEC[k][15:8]);
            check("R4/R5/R6/R7 pu", pad_pu, VEC[k][7:0]);
            read_reg(2'd1, rv); check("R2 dir readback", rv, VEC[k][47:40]);
            read_reg(2'd2, rv); check("R2 level readback", rv, VEC[k][39:32]);
        end
        pu_disable = 1'b0;

        // R6 kill toggled live with pull-ups requested
        bus_write(2'd1, 8'h00);
        bus_write(2'd2, 8'hFF);
        pu_disable = 1'b1; #0.5;
        check("R6 live kill", pad_pu, 8'h00);
        pu_disable = 1'b0; #0.5;
        check("R5 pull-up back", pad_pu, 8'hFF);

        // R2 address 3 reads zero
        read_reg(2'd3, rv); check("R2 addr3 reads 0", rv, 8'h00);

        // R3 stray writes
        bus_write(2'd1, 8'h00);
        bus_write(2'd2, 8'h00);
        bus_write(2'd0, 8'hFF);
        bus_write(2'd3, 8'hFF);
        check("R3 oe", pad_oe, 8'h00);
        check("R3 pu", pad_pu, 8'h00);
        read_reg(2'd1, rv); check("R3 dir", rv, 8'h00);
        read_reg(2'd2, rv); check("R3 level", rv, 8'h00);

        // R8 float -> pull-up -> drive high
        bus_write(2'd2, 8'hFF);
        check("R8 step oe", pad_oe, 8'h00);
        check("R8 step pu", pad_pu, 8'hFF);
        bus_write(2'd1, 8'hFF);
        check("R8 final oe", pad_oe, 8'hFF);
        check("R8 final out", pad_out, 8'hFF);
        check("R8 final pu", pad_pu, 8'h00);

        // R9 output reads back pad
        @(negedge clk); pad_in = 8'hA5;
        @(negedge clk);
        read_reg(2'd0, rv); check("R9 driven readback", rv, 8'hA5);
        bus_write(2'd1, 8'h00);
        @(negedge clk); pad_in = 8'h3C;
        @(negedge clk);
        read_reg(2'd0, rv); check("R9 input readback", rv, 8'h3C);

        // R10 change during low phase
        addr = 2'd0;
        @(negedge clk); #0.5 pad_in = 8'h81;
        #0.5 check("R10 low-phase before edge", rd_data, 8'h3C);
        @(posedge clk); #0.5 check("R10 low-phase after edge", rd_data, 8'h81);

        // R10 change during high phase
        @(posedge clk); #0.5 pad_in = 8'h7E;
        @(negedge clk); #1 check("R10 high-phase held", rd_data, 8'h81);
        @(posedge clk); #0.5 check("R10 high-phase after edge", rd_data, 8'h7E);

        // R11 glitch inside high phase
        @(posedge clk); #0.5 pad_in = 8'h00;
        #1 pad_in = 8'h7E;
        @(posedge clk); #0.5 check("R11 glitch ignored", rd_data, 8'h7E);
        @(posedge clk); #0.5 check("R11 glitch still ignored", rd_data, 8'h7E);

        // R1 reset again clears everything
        bus_write(2'd1, 8'hFF);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 re-reset oe", pad_oe, 8'h00);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule